// File: doc/BRIEF.md
# Sticky Lock and Erase Status Registers

This block holds the configuration bits that software may turn on but never turn off, together with a status register that memories set when an erase finishes. Three groups of set-only lock bits drive write-disable outputs for protected CPU register groups. A fourth group, the fault-routing locks, decides which fault sources reach a combined timer break output. One of those fault-routing bits also freezes the voltage-detector configuration.

Two reset inputs exist. The system reset returns locks, configuration and the cache erase flag to zero. The power-on reset does all of that as well. It also clears the two items that must outlive a system reset: the full-memory erase flag and a 16-bit command register. Software reaches every register through a simple single-cycle write strobe with an address and data. Read data is a combinational decode of the address. Access filtering is done elsewhere.

Top module: `sticky_lock_ctrl`

## Requirements
- R1: The non-secure CPU lock register (offset 0x00, bits 1:0) and the secure CPU lock register (offset 0x04, bits 2:0) are set-only. Writing 1 to a bit sets it and drives the matching lock output. Writing 0 leaves it unchanged. A system reset clears it.
- R2: The fault-routing lock register (offset 0x08) is set-only with the same rules as R1. Its bits are: bit 0 CPU lockup, bit 1 SRAM ECC error, bit 2 voltage-detector event, bit 3 flash ECC double error. Fault input `flt_i[k]` belongs to bit k.
- R3: `brk_o` equals the OR over k of `flt_i[k]` AND lock bit k, registered once. It therefore follows the inputs one clock later.
- R4: The voltage-detector configuration at offset 0x10 has bit 0 as enable and bits 3:1 as level. It takes writes only while fault-routing lock bit 2 is clear. While that bit is set, the configuration and its outputs hold their value.
- R5: Erase status bit 0 (offset 0x0C) is set by a pulse on `full_erase_done_i` and is cleared by writing 1 to it. A system reset leaves it unchanged, and only power-on reset clears it.
- R6: Erase status bit 16 (offset 0x0C) is set by a pulse on `cache_erase_done_i` and is cleared by writing 1 to it. Writing 0 has no effect. A system reset clears it.
- R7: When a hardware set and a software write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R8: The command register at offset 0x2C keeps bits 15:0 of the written data. Only power-on reset clears it, and it keeps its value across a system reset.
- R9: Power-on reset clears every register and output, including the items R5 and R8 preserve across a system reset. Writes presented while either reset is active are ignored.
- R10: Unmapped offsets read as zero, and unused bits of mapped registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst_n | input | 1 | Power-on reset, active low, synchronous |
| sys_rst_n | input | 1 | System reset, active low, synchronous |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | 8 | Byte offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| flt_i | input | 4 | Fault sources: lockup, SRAM ECC, voltage detector, flash ECC |
| full_erase_done_i | input | 1 | Pulse when the full memory erase completes |
| cache_erase_done_i | input | 1 | Pulse when the cache and crypto-RAM erase completes |
| ns_lock_o | output | 2 | Non-secure CPU write-disable outputs |
| s_lock_o | output | 3 | Secure CPU write-disable outputs |
| flt_lock_o | output | 4 | Fault-routing enables |
| brk_o | output | 1 | Registered combined break |
| vdet_en_o | output | 1 | Voltage-detector enable |
| vdet_lvl_o | output | 3 | Voltage-detector level |
| cmd_o | output | 16 | Command register contents |

## Verification
An erase-done pulse from a memory and a software write-1 clear to the same status bit can land on one clock edge. The bench provokes this by raising the done input and the write strobe on the same falling edge. It does so for both status bits, once with the bit already set and once with it clear. The register is read back afterwards and must show the bit set. A separate write-1 without a pulse must still clear it, which shows that the clear path works at all.

// File: rtl/lkst_pkg.sv
package lkst_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 8;
  localparam int NS_W     = 2;
  localparam int S_W      = 3;
  localparam int FLT_W    = 4;
  localparam int CMD_W    = 16;
  localparam int VLVL_W   = 3;

  localparam logic [7:0] OFS_NSLOCK = 8'h00;
  localparam logic [7:0] OFS_SLOCK  = 8'h04;
  localparam logic [7:0] OFS_FLTLCK = 8'h08;
  localparam logic [7:0] OFS_ERASE  = 8'h0C;
  localparam logic [7:0] OFS_VDET   = 8'h10;
  localparam logic [7:0] OFS_CMD    = 8'h2C;

  localparam int FULL_BIT  = 0;
  localparam int CACHE_BIT = 16;

  // fault-routing bit positions
  localparam int FLT_LOCKUP = 0;
  localparam int FLT_SRAM   = 1;
  localparam int FLT_VDET   = 2;
  localparam int FLT_FLASH  = 3;

  function automatic logic set_only_next(input logic q, input logic hit, input logic wbit);
    return q | (hit & wbit);
  endfunction

  function automatic logic w1c_next(input logic q, input logic hw_set, input logic sw_clr);
    if (hw_set) return 1'b1;
    if (sw_clr) return 1'b0;
    return q;
  endfunction

  function automatic logic brk_fold(input logic [FLT_W-1:0] flt, input logic [FLT_W-1:0] en);
    return |(flt & en);
  endfunction
endpackage

// File: rtl/lkst_setonly.sv
module lkst_setonly #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  import lkst_pkg::*;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= set_only_next(q[i], wr_hit, wdata[i]);
    end

    assert_lock_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
      q[i] |=> q[i]);
    assert_lock_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wdata[i]) |=> q[i]);
  end
endmodule

// File: rtl/lkst_w1c_bit.sv
module lkst_w1c_bit #(
  parameter bit POR_ONLY = 1'b0
) (
  input  logic clk,
  input  logic por_rst_n,
  input  logic sys_rst_n,
  input  logic hw_set,
  input  logic sw_clr,
  output logic q
);
  import lkst_pkg::*;

  logic clr_now;

  if (POR_ONLY) begin : g_por
    assign clr_now = !por_rst_n;
    assert_keep_sysrst_R5: assert property (@(posedge clk) disable iff (!por_rst_n)
      (!sys_rst_n && q) |=> q);
  end else begin : g_sys
    assign clr_now = !por_rst_n || !sys_rst_n;
    assert_clr_sysrst_R6: assert property (@(posedge clk) disable iff (!por_rst_n)
      (!sys_rst_n) |=> !q);
  end

  always_ff @(posedge clk) begin
    if (clr_now) q <= 1'b0;
    else         q <= w1c_next(q, hw_set, sw_clr);
  end

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (clr_now)
    hw_set |=> q);
endmodule

// File: rtl/lkst_brk.sv
module lkst_brk #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] flt,
  input  logic [N-1:0] en,
  output logic         brk
);
  import lkst_pkg::*;

  logic gated_any;
  assign gated_any = |(flt & en);

  always_ff @(posedge clk) begin
    if (!rst_n) brk <= 1'b0;
    else        brk <= gated_any;
  end

  assert_brk_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gated_any |=> brk);
  assert_brk_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !gated_any |=> !brk);
endmodule

// File: rtl/sticky_lock_ctrl.sv
module sticky_lock_ctrl
  import lkst_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int NSW   = NS_W,
  parameter int SW    = S_W,
  parameter int FW    = FLT_W,
  parameter int CW    = CMD_W,
  parameter int LVLW  = VLVL_W
) (
  input  logic            clk,
  input  logic            por_rst_n,
  input  logic            sys_rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic [FW-1:0]   flt_i,
  input  logic            full_erase_done_i,
  input  logic            cache_erase_done_i,
  output logic [NSW-1:0]  ns_lock_o,
  output logic [SW-1:0]   s_lock_o,
  output logic [FW-1:0]   flt_lock_o,
  output logic            brk_o,
  output logic            vdet_en_o,
  output logic [LVLW-1:0] vdet_lvl_o,
  output logic [CW-1:0]   cmd_o
);
  localparam int VCFG_W = LVLW + 1;

  logic sys_ok;
  assign sys_ok = por_rst_n & sys_rst_n;

  // decoded write strobes, inactive during any reset
  logic wr_ok, hit_ns, hit_s, hit_flt, hit_erase, hit_vdet, hit_cmd;
  assign wr_ok     = reg_wr & sys_ok;
  assign hit_ns    = wr_ok && (reg_addr == AW'(OFS_NSLOCK));
  assign hit_s     = wr_ok && (reg_addr == AW'(OFS_SLOCK));
  assign hit_flt   = wr_ok && (reg_addr == AW'(OFS_FLTLCK));
  assign hit_erase = wr_ok && (reg_addr == AW'(OFS_ERASE));
  assign hit_vdet  = wr_ok && (reg_addr == AW'(OFS_VDET));
  assign hit_cmd   = wr_ok && (reg_addr == AW'(OFS_CMD));

  logic [NSW-1:0] ns_q;
  logic [SW-1:0]  s_q;
  logic [FW-1:0]  flt_q;

  lkst_setonly #(.W(NSW)) u_ns_lock (
    .clk(clk), .rst_n(sys_ok), .wr_hit(hit_ns), .wdata(reg_wdata[NSW-1:0]), .q(ns_q));
  lkst_setonly #(.W(SW)) u_s_lock (
    .clk(clk), .rst_n(sys_ok), .wr_hit(hit_s), .wdata(reg_wdata[SW-1:0]), .q(s_q));
  lkst_setonly #(.W(FW)) u_flt_lock (
    .clk(clk), .rst_n(sys_ok), .wr_hit(hit_flt), .wdata(reg_wdata[FW-1:0]), .q(flt_q));

  // erase status flags
  logic st_full, st_cache;
  logic clr_full, clr_cache;
  assign clr_full  = hit_erase & reg_wdata[FULL_BIT];
  assign clr_cache = hit_erase & reg_wdata[CACHE_BIT];

  lkst_w1c_bit #(.POR_ONLY(1'b1)) u_st_full (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .hw_set(full_erase_done_i), .sw_clr(clr_full), .q(st_full));
  lkst_w1c_bit #(.POR_ONLY(1'b0)) u_st_cache (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .hw_set(cache_erase_done_i), .sw_clr(clr_cache), .q(st_cache));

  // voltage-detector configuration, frozen by its fault-routing lock
  logic [VCFG_W-1:0] vdet_q;
  logic vdet_frozen;
  assign vdet_frozen = flt_q[FLT_VDET];

  always_ff @(posedge clk) begin
    if (!sys_ok) vdet_q <= '0;
    else if (hit_vdet && !vdet_frozen) vdet_q <= reg_wdata[VCFG_W-1:0];
  end

  // command register, power-on domain only
  logic [CW-1:0] cmd_q;
  always_ff @(posedge clk) begin
    if (!por_rst_n) cmd_q <= '0;
    else if (hit_cmd) cmd_q <= reg_wdata[CW-1:0];
  end

  lkst_brk #(.N(FW)) u_brk (
    .clk(clk), .rst_n(sys_ok), .flt(flt_i), .en(flt_q), .brk(brk_o));

  assign ns_lock_o  = ns_q;
  assign s_lock_o   = s_q;
  assign flt_lock_o = flt_q;
  assign vdet_en_o  = vdet_q[0];
  assign vdet_lvl_o = vdet_q[VCFG_W-1:1];
  assign cmd_o      = cmd_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      AW'(OFS_NSLOCK): reg_rdata[NSW-1:0] = ns_q;
      AW'(OFS_SLOCK):  reg_rdata[SW-1:0]  = s_q;
      AW'(OFS_FLTLCK): reg_rdata[FW-1:0]  = flt_q;
      AW'(OFS_ERASE): begin
        reg_rdata[FULL_BIT]  = st_full;
        reg_rdata[CACHE_BIT] = st_cache;
      end
      AW'(OFS_VDET):   reg_rdata[VCFG_W-1:0] = vdet_q;
      AW'(OFS_CMD):    reg_rdata[CW-1:0] = cmd_q;
      default:         reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata[DW-1:CACHE_BIT+1];

  assert_vdet_frozen_R4: assert property (@(posedge clk) disable iff (!sys_ok)
    vdet_frozen |=> $stable(vdet_q));
  assert_cmd_keep_R8: assert property (@(posedge clk) disable iff (!por_rst_n)
    (!sys_rst_n) |=> $stable(cmd_q));
  assert_brk_locked_off_R2: assert property (@(posedge clk) disable iff (!sys_ok)
    (flt_q == '0) |=> !brk_o);
endmodule

// File: tb/sticky_lock_ctrl_tb.sv
module sticky_lock_ctrl_tb;
  logic        clk = 1'b0;
  logic        por_rst_n = 1'b0, sys_rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  flt_i = '0;
  logic        full_erase_done_i = 1'b0, cache_erase_done_i = 1'b0;
  logic [1:0]  ns_lock_o;
  logic [2:0]  s_lock_o;
  logic [3:0]  flt_lock_o;
  logic        brk_o, vdet_en_o;
  logic [2:0]  vdet_lvl_o;
  logic [15:0] cmd_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sticky_lock_ctrl u_dut (
    .clk(clk), .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .flt_i(flt_i), .full_erase_done_i(full_erase_done_i), .cache_erase_done_i(cache_erase_done_i),
    .ns_lock_o(ns_lock_o), .s_lock_o(s_lock_o), .flt_lock_o(flt_lock_o), .brk_o(brk_o),
    .vdet_en_o(vdet_en_o), .vdet_lvl_o(vdet_lvl_o), .cmd_o(cmd_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic pf = 1'b0, input logic pc = 1'b0);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    full_erase_done_i = pf; cache_erase_done_i = pc;
    @(negedge clk);
    reg_wr = 1'b0; full_erase_done_i = 1'b0; cache_erase_done_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic sys_pulse();
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
  endtask

  task automatic por_pulse();
    @(negedge clk); por_rst_n = 1'b0;
    @(negedge clk); por_rst_n = 1'b1;
  endtask

  task automatic erase_pulse(input logic pf, input logic pc);
    @(negedge clk); full_erase_done_i = pf; cache_erase_done_i = pc;
    @(negedge clk); full_erase_done_i = 1'b0; cache_erase_done_i = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    rd(8'h00, d); chk("R9 ns lock after reset", d, 0);
    rd(8'h08, d); chk("R9 fault lock after reset", d, 0);
    rd(8'h0C, d); chk("R9 erase status after reset", d, 0);
    rd(8'h2C, d); chk("R9 cmd after reset", d, 0);
    chk("R9 brk after reset", {31'd0, brk_o}, 0);
  endtask

  task automatic t_cpu_locks();
    logic [31:0] d;
    wr(8'h00, 32'h3); rd(8'h00, d); chk("R1 ns lock set", d, 3);
    chk("R1 ns lock output", {30'd0, ns_lock_o}, 3);
    wr(8'h00, 32'h0); rd(8'h00, d); chk("R1 ns lock write0 ignored", d, 3);
    wr(8'h04, 32'h2); rd(8'h04, d); chk("R1 s lock single bit", d, 2);
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, d); chk("R10 s lock unused bits zero", d, 7);
    chk("R1 s lock output", {29'd0, s_lock_o}, 7);
    sys_pulse();
    rd(8'h00, d); chk("R1 ns lock cleared by sys reset", d, 0);
    rd(8'h04, d); chk("R1 s lock cleared by sys reset", d, 0);
  endtask

  task automatic t_fault_route();
    logic [31:0] d;
    @(negedge clk); flt_i = 4'hF;
    @(negedge clk); chk("R3 no break with locks clear", {31'd0, brk_o}, 0);
    for (int k = 0; k < 4; k++) begin
      sys_pulse();
      wr(8'h08, 32'(1 << k));
      chk("R2 fault lock output", {28'd0, flt_lock_o}, 32'(1 << k));
      @(negedge clk); flt_i = 4'(1 << k);
      @(negedge clk); chk("R2 routed fault gives break", {31'd0, brk_o}, 1);
      @(negedge clk); flt_i = ~4'(1 << k);
      @(negedge clk); chk("R2 other faults blocked", {31'd0, brk_o}, 0);
    end
    wr(8'h08, 32'h0); rd(8'h08, d); chk("R2 write0 keeps fault lock", d, 32'h8);
    @(negedge clk); flt_i = 4'h8;
    #1 chk("R3 break not combinational", {31'd0, brk_o}, 0);
    @(negedge clk); chk("R3 break one clock later", {31'd0, brk_o}, 1);
    @(negedge clk); flt_i = 4'h0;
    @(negedge clk); chk("R3 break drops", {31'd0, brk_o}, 0);
    sys_pulse();
  endtask

  task automatic t_vdet_freeze();
    logic [31:0] d;
    wr(8'h10, 32'hB); rd(8'h10, d); chk("R4 vdet write", d, 32'hB);
    chk("R4 vdet outputs", {28'd0, vdet_lvl_o, vdet_en_o}, 32'hB);
    wr(8'h08, 32'h4);
    wr(8'h10, 32'h2); rd(8'h10, d); chk("R4 vdet frozen", d, 32'hB);
    chk("R4 vdet outputs frozen", {28'd0, vdet_lvl_o, vdet_en_o}, 32'hB);
    sys_pulse();
    wr(8'h10, 32'h6); rd(8'h10, d); chk("R4 vdet writable after unlock", d, 32'h6);
    sys_pulse();
  endtask

  task automatic t_erase_status();
    logic [31:0] d;
    erase_pulse(1'b1, 1'b0); rd(8'h0C, d); chk("R5 full erase sets bit0", d, 32'h1);
    erase_pulse(1'b0, 1'b1); rd(8'h0C, d); chk("R6 cache erase sets bit16", d, 32'h10001);
    wr(8'h0C, 32'h0); rd(8'h0C, d); chk("R6 write0 no effect", d, 32'h10001);
    wr(8'h0C, 32'h1); rd(8'h0C, d); chk("R5 w1c bit0", d, 32'h10000);
    wr(8'h0C, 32'h10000); rd(8'h0C, d); chk("R6 w1c bit16", d, 32'h0);
    erase_pulse(1'b1, 1'b1);
    sys_pulse();
    rd(8'h0C, d); chk("R5 R6 sys reset keeps bit0 clears bit16", d, 32'h1);
    por_pulse();
    rd(8'h0C, d); chk("R5 por clears bit0", d, 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] d;
    wr(8'h0C, 32'h10001, 1'b1, 1'b1); rd(8'h0C, d);
    chk("R7 set beats clear from zero", d, 32'h10001);
    wr(8'h0C, 32'h10001, 1'b1, 1'b1); rd(8'h0C, d);
    chk("R7 set beats clear when set", d, 32'h10001);
    wr(8'h0C, 32'h10001); rd(8'h0C, d); chk("R7 plain clear still works", d, 32'h0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr(8'h2C, 32'hA5C3); rd(8'h2C, d); chk("R8 cmd write", d, 32'hA5C3);
    wr(8'h2C, 32'hFFFF_FFFF); rd(8'h2C, d); chk("R8 cmd width 16", d, 32'hFFFF);
    sys_pulse();
    rd(8'h2C, d); chk("R8 cmd survives sys reset", d, 32'hFFFF);
    chk("R8 cmd output", {16'd0, cmd_o}, 32'hFFFF);
  endtask

  task automatic t_por_all();
    logic [31:0] d;
    wr(8'h00, 32'h3); wr(8'h04, 32'h7); wr(8'h10, 32'h5); wr(8'h08, 32'hF);
    erase_pulse(1'b1, 1'b1);
    @(negedge clk); flt_i = 4'h1;
    @(negedge clk); chk("R3 break before por", {31'd0, brk_o}, 1);
    por_pulse();
    flt_i = 4'h0;
    chk("R9 por clears locks", {23'd0, ns_lock_o, s_lock_o, flt_lock_o}, 0);
    chk("R9 por clears vdet", {28'd0, vdet_lvl_o, vdet_en_o}, 0);
    rd(8'h0C, d); chk("R9 por clears status", d, 0);
    rd(8'h2C, d); chk("R9 por clears cmd", d, 0);
    @(negedge clk); sys_rst_n = 1'b0; reg_wr = 1'b1; reg_addr = 8'h2C; reg_wdata = 32'h1234;
    @(negedge clk); sys_rst_n = 1'b1; reg_wr = 1'b0;
    rd(8'h2C, d); chk("R9 write during reset ignored", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); chk("R10 unmapped 0x14", d, 0);
    rd(8'h30, d); chk("R10 unmapped 0x30", d, 0);
  endtask

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    por_rst_n = 1'b1; sys_rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_cpu_locks();
    t_fault_route();
    t_vdet_freeze();
    t_erase_status();
    t_collision();
    t_cmd();
    t_por_all();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule